// File: doc/BRIEF.md
# Per-Tile Object Reference List Allocator

This block builds the per-tile object lists of a tile-based deferred renderer. Each accepted request gives a tile column and row, one of five primitive classes and a 24-bit object address. The block appends that address to the list that belongs to the tile and class, and writes it through a simple word-write memory port. Every list begins in a fixed first segment. The first segments form one matrix per class, and the matrices are placed back to back from a base address.

The segment size of each class comes from a 2-bit code in a control word. In every segment the last word is kept for a link. When a tail segment is full, the block takes a fresh segment from an overflow pool that grows downward from an allocation pointer. It writes the new segment's address into the link word of the full segment, and on the next cycle it writes the object into the new segment. A lower-limit address guards the pool. A request that would allocate below it is dropped and raises a sticky flag.

Requests with a disabled class, a class index above 4, or a tile outside the configured grid are dropped, and a saturating error counter counts them. An init strobe restarts all lists, loads the allocation pointer and clears both error indications.

Top module: `tile_objlist_alloc`

## Requirements
- R1: The class matrices follow each other in this order: index 0 opaque polygon, 1 opaque modifier, 2 translucent polygon, 3 translucent modifier, 4 punch-through. Matrix k starts at mat_base_i plus the sum, over the classes below k, of cols*rows*seg_bytes. Here cols = tiles_wm1_i+1 and rows = tiles_hm1_i+1. The first segment of a tile (x,y) lies at matrix_start + (cols*y + x)*seg_bytes.
- R2: The size code of class k is taken from ctrl_i[4k+1:4k]. Code 1, 2 and 3 give segments of 32, 64 and 128 bytes, which hold 7, 15 and 31 objects. An accepted append writes {8'h00, object} to tail + 4*fill, with mem_we_o high on the cycle after acceptance.
- R3: An append is dropped and err_cnt_o increments by one, saturating at all ones, in any of these cases: the class code is 0, app_cls_i > 4, app_x_i > tiles_wm1_i, or app_y_i > tiles_hm1_i. No memory write follows a dropped append.
- R4: An append to a full tail segment takes new = alloc - seg_bytes. It writes {8'h00, new} to tail + 4*capacity. On the next cycle it writes the object to new. The new segment becomes the tail, with fill 1.
- R5: The allocation pointer only moves downward between inits, so successive overflow segments of any tile or class stack at lower addresses.
- R6: app_ready_o is low during the cycle in which a link write is on the port, and high again when the object write of that link is presented.
- R7: If alloc < seg_bytes or alloc - seg_bytes < lim_i, the append writes nothing and ovf_o is set. ovf_o stays set until init. The fill of that list is unchanged, so later appends to it are dropped too.
- R8: After reset, or after init_i, no write is pending, ovf_o and err_cnt_o are 0, the allocation pointer equals alloc_start_i (0 after reset), and every list is empty and back in its first segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Per-class segment size codes |
| mat_base_i | input | 24 | Start address of the first class matrix |
| lim_i | input | 24 | Lowest address the overflow pool may use |
| alloc_start_i | input | 24 | Allocation pointer value loaded by init |
| init_i | input | 1 | Restart strobe |
| tiles_wm1_i | input | 2 | Grid width in tiles minus one |
| tiles_hm1_i | input | 2 | Grid height in tiles minus one |
| app_valid_i | input | 1 | Append request |
| app_ready_o | output | 1 | Append accepted when high with app_valid_i |
| app_x_i | input | 2 | Tile column |
| app_y_i | input | 2 | Tile row |
| app_cls_i | input | 3 | Primitive class index |
| app_obj_i | input | 24 | Object address to append |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| ovf_o | output | 1 | Sticky pool-exhausted flag |
| err_cnt_o | output | 8 | Saturating count of dropped bad appends |

## Verification
The first pattern sweeps every tile and class with all codes at 1, once and then a second time, on a 3 by 2 grid. This shows whether the matrix offsets, the row-major order and the fill step are right. A second configuration mixes codes, has one class disabled and uses a full 4 by 4 grid, so a wrong bit field or a wrong per-class size moves the addresses. Repeated appends to single tiles until their segments are full exercise the link word, the downward stacking and the two-cycle handshake. A tight lower limit then shows the exact point at which the pool runs out. Bad coordinates and classes, and a run past the error counter's width, test that bad requests are dropped and that the counter saturates.

// File: rtl/olpa_pkg.sv
package olpa_pkg;

    localparam int NCLS = 5;   // primitive classes
    localparam int CW   = 3;   // class index width
    localparam int SBW  = 8;   // segment byte count width
    localparam int FW   = 5;   // fill / capacity width

    typedef enum logic [CW-1:0] {
        CLS_OPQ_POLY  = 3'd0,
        CLS_OPQ_MOD   = 3'd1,
        CLS_TRN_POLY  = 3'd2,
        CLS_TRN_MOD   = 3'd3,
        CLS_PUNCH     = 3'd4
    } prim_cls_e;

    // bytes per segment for a size code (0 means class disabled)
    function automatic logic [SBW-1:0] seg_bytes(input logic [1:0] code);
        return (code == 2'd0) ? '0 : SBW'(8'd16 << code);
    endfunction

    // objects per segment: all words except the link word
    function automatic logic [FW-1:0] seg_cap(input logic [1:0] code);
        return (code == 2'd0) ? '0 : FW'((6'd4 << code) - 6'd1);
    endfunction

endpackage

// File: rtl/olpa_cfg_dec.sv
module olpa_cfg_dec
    import olpa_pkg::*;
(
    input  logic [31:0]               ctrl_i,
    output logic [NCLS-1:0][SBW-1:0]  sb_o,
    output logic [NCLS-1:0][FW-1:0]   cap_o
);

    generate
        for (genvar k = 0; k < NCLS; k++) begin : g_cls
            assign sb_o[k]  = seg_bytes(ctrl_i[4*k +: 2]);
            assign cap_o[k] = seg_cap(ctrl_i[4*k +: 2]);
        end
    endgenerate

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl_i[31:18], ctrl_i[15:14], ctrl_i[11:10],
                           ctrl_i[7:6], ctrl_i[3:2]};

endmodule

// File: rtl/olpa_first_addr.sv
module olpa_first_addr
    import olpa_pkg::*;
#(
    parameter int AW = 24,
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic [AW-1:0]             base_i,
    input  logic [XW-1:0]             wm1_i,
    input  logic [YW-1:0]             hm1_i,
    input  logic [NCLS-1:0][SBW-1:0]  sb_i,
    input  logic [CW-1:0]             cls_i,
    input  logic [XW-1:0]             x_i,
    input  logic [YW-1:0]             y_i,
    output logic [AW-1:0]             addr_o
);

    logic [AW-1:0] cols, rows, ntile, start, own;

    always_comb begin
        cols  = AW'(wm1_i) + AW'(1);
        rows  = AW'(hm1_i) + AW'(1);
        ntile = cols * rows;
        start = base_i;
        own   = '0;
        for (int j = 0; j < NCLS; j++) begin
            if (CW'(j) < cls_i) start = start + ntile * AW'(sb_i[j]);
            if (CW'(j) == cls_i) own = AW'(sb_i[j]);
        end
        addr_o = start + (cols * AW'(y_i) + AW'(x_i)) * own;
    end

endmodule

// File: rtl/tile_objlist_alloc.sv
module tile_objlist_alloc
    import olpa_pkg::*;
#(
    parameter int TX_MAX = 4,
    parameter int TY_MAX = 4,
    parameter int AW     = 24,
    parameter int ECW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_i,
    input  logic [AW-1:0]     mat_base_i,
    input  logic [AW-1:0]     lim_i,
    input  logic [AW-1:0]     alloc_start_i,
    input  logic              init_i,
    input  logic [$clog2(TX_MAX)-1:0] tiles_wm1_i,
    input  logic [$clog2(TY_MAX)-1:0] tiles_hm1_i,
    input  logic              app_valid_i,
    output logic              app_ready_o,
    input  logic [$clog2(TX_MAX)-1:0] app_x_i,
    input  logic [$clog2(TY_MAX)-1:0] app_y_i,
    input  logic [CW-1:0]     app_cls_i,
    input  logic [AW-1:0]     app_obj_i,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic              ovf_o,
    output logic [ECW-1:0]    err_cnt_o
);

    localparam int XW = $clog2(TX_MAX);
    localparam int YW = $clog2(TY_MAX);
    localparam int NT = TX_MAX * TY_MAX;
    localparam int NE = NCLS * NT;
    localparam int IW = $clog2(NE) + 1;

    typedef struct packed {
        logic            busy;
        logic [AW-1:0]   pend_addr;
        logic [AW-1:0]   pend_obj;
        logic [AW-1:0]   alloc;
        logic            ovf;
        logic [ECW-1:0]  err;
        logic            we;
        logic [AW-1:0]   addr;
        logic [31:0]     wdata;
    } st_t;

    st_t s_d, s_q;
    logic [FW-1:0] fill_d [NE];
    logic [FW-1:0] fill_q [NE];
    logic [AW-1:0] tail_d [NE];
    logic [AW-1:0] tail_q [NE];
    logic          lnk_d  [NE];
    logic          lnk_q  [NE];

    logic [NCLS-1:0][SBW-1:0] sb;
    logic [NCLS-1:0][FW-1:0]  cap;
    logic [AW-1:0]            first_addr;

    olpa_cfg_dec u_dec (
        .ctrl_i (ctrl_i),
        .sb_o   (sb),
        .cap_o  (cap)
    );

    olpa_first_addr #(.AW(AW), .XW(XW), .YW(YW)) u_first (
        .base_i (mat_base_i),
        .wm1_i  (tiles_wm1_i),
        .hm1_i  (tiles_hm1_i),
        .sb_i   (sb),
        .cls_i  (app_cls_i),
        .x_i    (app_x_i),
        .y_i    (app_y_i),
        .addr_o (first_addr)
    );

    // request decode
    logic [SBW-1:0] sb_sel;
    logic [FW-1:0]  cap_sel;
    logic           bad;
    logic [IW-1:0]  idx;
    logic [AW-1:0]  cur, nseg, sb_a;

    always_comb begin
        sb_sel  = '0;
        cap_sel = '0;
        for (int k = 0; k < NCLS; k++) begin
            if (CW'(k) == app_cls_i) begin
                sb_sel  = sb[k];
                cap_sel = cap[k];
            end
        end
        bad  = (app_cls_i >= CW'(NCLS)) || (sb_sel == '0) ||
               (app_x_i > tiles_wm1_i) || (app_y_i > tiles_hm1_i);
        idx  = IW'(app_cls_i) * IW'(NT) + IW'(app_y_i) * IW'(TX_MAX) + IW'(app_x_i);
        sb_a = AW'(sb_sel);
        nseg = s_q.alloc - sb_a;
    end

    assign app_ready_o = !s_q.busy && !init_i;

    always_comb begin
        s_d    = s_q;
        fill_d = fill_q;
        tail_d = tail_q;
        lnk_d  = lnk_q;
        s_d.we = 1'b0;
        cur    = '0;
        if (init_i) begin
            for (int e = 0; e < NE; e++) begin
                fill_d[e] = '0;
                lnk_d[e]  = 1'b0;
            end
            s_d.alloc = alloc_start_i;
            s_d.ovf   = 1'b0;
            s_d.err   = '0;
            s_d.busy  = 1'b0;
        end else if (s_q.busy) begin
            s_d.we    = 1'b1;
            s_d.addr  = s_q.pend_addr;
            s_d.wdata = 32'(s_q.pend_obj);
            s_d.busy  = 1'b0;
        end else if (app_valid_i) begin
            if (bad) begin
                if (s_q.err != '1) s_d.err = s_q.err + 1'b1;
            end else begin
                cur = lnk_q[idx] ? tail_q[idx] : first_addr;
                if (fill_q[idx] < cap_sel) begin
                    s_d.we       = 1'b1;
                    s_d.addr     = cur + AW'({fill_q[idx], 2'b00});
                    s_d.wdata    = 32'(app_obj_i);
                    fill_d[idx]  = fill_q[idx] + 1'b1;
                end else if ((s_q.alloc < sb_a) || (nseg < lim_i)) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.we        = 1'b1;
                    s_d.addr      = cur + AW'({cap_sel, 2'b00});
                    s_d.wdata     = 32'(nseg);
                    s_d.alloc     = nseg;
                    s_d.busy      = 1'b1;
                    s_d.pend_addr = nseg;
                    s_d.pend_obj  = app_obj_i;
                    tail_d[idx]   = nseg;
                    lnk_d[idx]    = 1'b1;
                    fill_d[idx]   = FW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int e = 0; e < NE; e++) begin
                fill_q[e] <= '0;
                tail_q[e] <= '0;
                lnk_q[e]  <= 1'b0;
            end
        end else begin
            s_q    <= s_d;
            fill_q <= fill_d;
            tail_q <= tail_d;
            lnk_q  <= lnk_d;
        end
    end

    assign mem_we_o    = s_q.we;
    assign mem_addr_o  = s_q.addr;
    assign mem_wdata_o = s_q.wdata;
    assign ovf_o       = s_q.ovf;
    assign err_cnt_o   = s_q.err;

    // R6: while the object write is pending, the link word is on the port
    a_r6_link_on_port: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (mem_we_o && !app_ready_o))
        else $error("link write missing while object write pending");

    // R7: a new segment never lies below the limit
    a_r7_seg_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.pend_addr >= lim_i))
        else $error("segment allocated below limit");

    // R7: overflow flag is sticky until init
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !init_i) |=> ovf_o)
        else $error("overflow flag dropped without init");

    // R5: allocation pointer never moves upward between inits
    a_r5_alloc_down: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (s_q.alloc <= $past(s_q.alloc)))
        else $error("allocation pointer moved up");

    // R3: error counter never decreases between inits
    a_r3_err_mono: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (err_cnt_o >= $past(err_cnt_o)))
        else $error("error counter decreased");

    // R3: a dropped bad request causes no memory write
    a_r3_bad_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (app_valid_i && app_ready_o && bad) |=> !mem_we_o)
        else $error("write after bad request");

endmodule

// File: tb/tile_objlist_alloc_tb.sv
module tile_objlist_alloc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl = '0;
    logic [23:0] mat_base = '0, lim = '0, astart = '0;
    logic        init = 1'b0;
    logic [1:0]  wm1 = '0, hm1 = '0;
    logic        app_valid = 1'b0;
    logic        app_ready;
    logic [1:0]  app_x = '0, app_y = '0;
    logic [2:0]  app_cls = '0;
    logic [23:0] app_obj = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        ovf;
    logic [7:0]  err_cnt;

    always #5 clk = ~clk;

    tile_objlist_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .mat_base_i(mat_base),
        .lim_i(lim), .alloc_start_i(astart), .init_i(init),
        .tiles_wm1_i(wm1), .tiles_hm1_i(hm1),
        .app_valid_i(app_valid), .app_ready_o(app_ready),
        .app_x_i(app_x), .app_y_i(app_y), .app_cls_i(app_cls), .app_obj_i(app_obj),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .ovf_o(ovf), .err_cnt_o(err_cnt)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    int mfill [80];
    int mtail [80];
    bit mlnk  [80];
    int malloc, merr;
    bit movf;
    int objn = 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int code_of(int c);
        return int'(ctrl[4*c +: 2]);
    endfunction
    function automatic int sbytes(int c);
        return (code_of(c) == 0) ? 0 : (16 << code_of(c));
    endfunction
    function automatic int capof(int c);
        return (code_of(c) == 0) ? 0 : ((4 << code_of(c)) - 1);
    endfunction
    function automatic int first_of(int c, int x, int y);
        int cols = int'(wm1) + 1;
        int rows = int'(hm1) + 1;
        int a = int'(mat_base);
        for (int j = 0; j < c; j++) a += cols * rows * sbytes(j);
        return a + (cols * y + x) * sbytes(c);
    endfunction

    task automatic do_init();
        @(negedge clk);
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        for (int e = 0; e < 80; e++) begin
            mfill[e] = 0; mlnk[e] = 0; mtail[e] = 0;
        end
        malloc = int'(astart); merr = 0; movf = 0;
        chk("R8 init ovf", 32'(ovf), 0);
        chk("R8 init err", 32'(err_cnt), 0);
        chk("R8 init no write", 32'(mem_we), 0);
    endtask

    task automatic app(input int x, input int y, input int c);
        bit bad;
        int e, cur, nw, sb, cp;
        logic [23:0] obj;
        obj = 24'(objn * 24'h1357 + 24'h0a0000);
        objn++;
        bad = (c > 4) || (x > int'(wm1)) || (y > int'(hm1));
        if (!bad && code_of(c) == 0) bad = 1;
        e = bad ? 0 : c * 16 + y * 4 + x;
        @(negedge clk);
        chk("R6 ready idle", 32'(app_ready), 1);
        app_valid = 1'b1;
        app_x = 2'(x); app_y = 2'(y); app_cls = 3'(c); app_obj = obj;
        @(negedge clk);
        app_valid = 1'b0;
        if (bad) begin
            if (merr < 255) merr++;
            chk("R3 dropped no write", 32'(mem_we), 0);
        end else begin
            sb = sbytes(c);
            cp = capof(c);
            cur = mlnk[e] ? mtail[e] : first_of(c, x, y);
            if (mfill[e] < cp) begin
                chk(mlnk[e] ? "R2 write en" : "R1 write en", 32'(mem_we), 1);
                chk(mlnk[e] ? "R2 addr" : "R1 addr", 32'(mem_addr), 32'(cur + 4 * mfill[e]));
                chk("R2 data", mem_wdata, 32'(obj));
                mfill[e]++;
            end else if (malloc < sb || (malloc - sb) < int'(lim)) begin
                movf = 1;
                chk("R7 no write", 32'(mem_we), 0);
            end else begin
                nw = malloc - sb;
                chk("R4 link we", 32'(mem_we), 1);
                chk("R4 link addr", 32'(mem_addr), 32'(cur + 4 * cp));
                chk("R4 link data", mem_wdata, 32'(nw));
                chk("R6 ready low", 32'(app_ready), 0);
                @(negedge clk);
                chk("R4 obj we", 32'(mem_we), 1);
                chk("R5 obj addr", 32'(mem_addr), 32'(nw));
                chk("R4 obj data", mem_wdata, 32'(obj));
                chk("R6 ready back", 32'(app_ready), 1);
                malloc = nw; mtail[e] = nw; mlnk[e] = 1; mfill[e] = 1;
            end
        end
        chk("R7 ovf", 32'(ovf), 32'(movf));
        chk("R3 err count", 32'(err_cnt), 32'(merr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset ready", 32'(app_ready), 1);
        chk("R8 reset we", 32'(mem_we), 0);
        chk("R8 reset ovf", 32'(ovf), 0);
        chk("R8 reset err", 32'(err_cnt), 0);
        rst_n = 1'b1;

        // config A: all classes code 1 on a 3x2 grid
        ctrl = 32'h0001_1111; mat_base = 24'h010000; astart = 24'h010000;
        lim = 24'h00fc00; wm1 = 2'd2; hm1 = 2'd1;
        do_init();
        for (int pass = 0; pass < 2; pass++)
            for (int c = 0; c < 5; c++)
                for (int y = 0; y < 2; y++)
                    for (int x = 0; x < 3; x++) app(x, y, c);
        for (int i = 0; i < 8; i++) app(1, 1, 2);   // R4 one link
        for (int i = 0; i < 20; i++) app(2, 0, 4);  // R5 stacked links
        app(3, 0, 0); app(0, 2, 1); app(0, 0, 5); app(1, 1, 7);  // R3

        // config B: mixed codes, class 1 disabled, full 4x4 grid
        ctrl = 32'h0003_1203; mat_base = 24'h020000; astart = 24'h020000;
        lim = 24'h01f000; wm1 = 2'd3; hm1 = 2'd3;
        do_init();
        for (int c = 0; c < 5; c++)
            for (int y = 0; y < 4; y++)
                for (int x = 0; x < 4; x++) app(x, y, c);
        for (int i = 0; i < 34; i++) app(3, 3, 0);  // R2 cap 31 then link
        for (int i = 0; i < 17; i++) app(0, 1, 2);  // cap 15 then link

        // config C: pool room for exactly four 32-byte segments
        ctrl = 32'h0001_1111; mat_base = 24'h020000; astart = 24'h020000;
        lim = 24'h01ff80; wm1 = 2'd1; hm1 = 2'd1;
        do_init();
        for (int i = 0; i < 40; i++) app(0, 0, 0);  // R7 exhaustion
        app(1, 1, 3);                               // room still left in first segment
        chk("R7 flag held", 32'(ovf), 1);
        do_init();                                  // R8 clears and restarts
        app(0, 0, 0);

        // R3 saturation
        for (int i = 0; i < 260; i++) app(0, 0, 6);
        chk("R3 saturated", 32'(err_cnt), 32'd255);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule